// File: doc/BRIEF.md
# Multi-Line Interrupt Status Controller

This block holds the interrupt state for two event sources, a processing-done event and a bus-error event. It presents that state on three independent interrupt lines. Each line keeps its own sticky raw status bits and its own enable bits. Software reaches them through a word-addressed 32-bit register port, with four registers per line: raw status, masked status, enable-set and enable-clear. Both event inputs are single-cycle pulses, and each pulse is recorded on every line at once.

The raw bits latch events whatever the enables hold. Software can also force a raw bit by writing it, which is useful for testing the interrupt path. Writing a one to the masked-status view acknowledges the event by clearing the raw bit, and this works even when the event is masked. Each line drives a level interrupt output, which is a registered OR of its masked status bits.

Top module: `irq_line_bank`

## Requirements
- R1: Line n (n = 0..2) has its registers at byte offsets 0x24 + 0x10·n (raw), 0x28 + 0x10·n (masked status), 0x2C + 0x10·n (enable-set) and 0x30 + 0x10·n (enable-clear). Every other address, including addresses that are not word aligned, reads 0 and ignores writes.
- R2: The done event uses data bit 8 and the error event uses data bit 0 in every register. All other bits read 0, and writing them has no effect.
- R3: An event pulse sets the matching raw bit on all three lines. The bit is visible on the next cycle, whether or not the event is enabled.
- R4: Writing 1 to a raw status bit sets it.
- R5: A masked status bit reads 1 only when both its raw bit and its enable bit are 1.
- R6: Writing 1 to a masked status bit clears the raw bit, even when that event is disabled.
- R7: Writing 1 to an enable-set bit enables the event, and writing 1 to an enable-clear bit disables it. Both registers read back the line's current enable vector.
- R8: Each interrupt output equals the OR of its line's masked status bits, delayed by one register stage.
- R9: When an event pulse and a clearing write to the same bit land in the same cycle, the bit stays set.
- R10: Writing 0 to any register bit leaves the state unchanged.
- R11: After a synchronous active-low reset, all raw bits, enable bits and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from the current state |
| evt_done | input | 1 | Processing-done event pulse |
| evt_err | input | 1 | Bus-error event pulse |
| irq_o | output | 3 | Level interrupt, one bit per line |

## Verification
Writes and event pulses are sampled on one clock edge, and status and enable bits show up on reg_rdata right after that edge. The interrupt outputs trail the status by one more edge. The bench's reference model mirrors this: it updates its state at each rising edge from the inputs held since the previous one, and it computes the expected interrupt from the state held before that update. Inputs change 2 ns after the rising edge, and both reg_rdata and irq_o are compared at every falling edge. Each comparison therefore sees exactly one edge's worth of change.

// File: rtl/irqb_pkg.sv
// Package: shared constants and helpers for the interrupt line bank.
// Assumes two event sources and a 32-bit register data path.
package irqb_pkg;
    localparam int DATA_W   = 32;
    localparam int EVT_N    = 2;
    localparam int EVT_ERR  = 0;   // index in internal event vectors
    localparam int EVT_DONE = 1;
    localparam int BIT_ERR  = 0;   // bit position on the register bus
    localparam int BIT_DONE = 8;

    typedef enum logic [1:0] {
        KIND_RAW   = 2'd0,
        KIND_STAT  = 2'd1,
        KIND_ENSET = 2'd2,
        KIND_ENCLR = 2'd3
    } reg_kind_e;

    // Spread an internal event vector onto the register bus.
    function automatic logic [DATA_W-1:0] to_bus(logic [EVT_N-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[BIT_ERR]  = v[EVT_ERR];
        r[BIT_DONE] = v[EVT_DONE];
        return r;
    endfunction

    // Gather the event bits out of a register bus word.
    function automatic logic [EVT_N-1:0] from_bus(logic [DATA_W-1:0] d);
        logic [EVT_N-1:0] r;
        r[EVT_ERR]  = d[BIT_ERR];
        r[EVT_DONE] = d[BIT_DONE];
        return r;
    endfunction
endpackage

// File: rtl/irqb_decode.sv
// Module: address decoder for the interrupt line bank.
// Splits a byte address into a line index and a register kind.
// Assumes STRIDE is a power of two, at least 16, and that it holds
// four word registers at its start.
module irqb_decode
    import irqb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 3,
    parameter int BASE      = 'h24,
    parameter int STRIDE    = 'h10,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [LINE_W-1:0] line,
    output reg_kind_e         kind
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_LINES * STRIDE);
    localparam logic [ADDR_W-1:0] STR_A  = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] lidx;

    // Offset into the bank, slot within a line, and range checks.
    always_comb begin
        off  = addr - BASE_A;
        slot = off % STR_A;
        lidx = off / STR_A;
        hit  = (addr >= BASE_A) && (off < SPAN_A) &&
               (slot < ADDR_W'(16)) && (slot[1:0] == 2'b00);
        line = lidx[LINE_W-1:0];
        kind = reg_kind_e'(slot[3:2]);
    end

    wire unused_decode = ^{lidx[ADDR_W-1:LINE_W], slot[ADDR_W-1:4]};
endmodule

// File: rtl/irqb_line.sv
// Module: state for one interrupt line. Holds the sticky raw bits, the
// enable bits and the registered interrupt output.
// Assumes the write strobes are mutually exclusive (one address per cycle).
module irqb_line
    import irqb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             wr_raw,
    input  logic             wr_stat,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [EVT_N-1:0] wbits,
    output logic [EVT_N-1:0] raw_o,
    output logic [EVT_N-1:0] en_o,
    output logic             irq_o
);
    logic [EVT_N-1:0] raw_q, en_q;
    logic             irq_q;

    // Raw bits: acknowledge first, then apply forced sets and events (event wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~(wr_stat ? wbits : '0)) | (wr_raw ? wbits : '0) | evt;
    end

    // Enable bits: set and clear through separate write-one registers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else
            en_q <= (en_q | (wr_set ? wbits : '0)) & ~(wr_clr ? wbits : '0);
    end

    // Interrupt level: registered OR of the masked status.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(raw_q & en_q);
    end

    assign raw_o = raw_q;
    assign en_o  = en_q;
    assign irq_o = irq_q;

    for (genvar k = 0; k < EVT_N; k++) begin : g_chk
        assert_evt_sets_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> raw_q[k]);
        assert_evt_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[k] && wr_stat && wbits[k]) |=> raw_q[k]);
        assert_ack_clears_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat && wbits[k] && !evt[k]) |=> !raw_q[k]);
        assert_enset_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_set && wbits[k]) |=> en_q[k]);
        assert_enclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr && wbits[k]) |=> !en_q[k]);
    end
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_q);
endmodule

// File: rtl/irq_line_bank.sv
// Module: top of the interrupt line bank. Decodes register accesses,
// fans the events out to every line and muxes the read data.
// Assumes reads are combinational from the address; writes take effect
// on the clock edge that samples reg_wr.
module irq_line_bank
    import irqb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 3,
    parameter int BASE      = 'h24,
    parameter int STRIDE    = 'h10,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 evt_done,
    input  logic                 evt_err,
    output logic [NUM_LINES-1:0] irq_o
);
    logic              dec_hit;
    logic [LINE_W-1:0] dec_line;
    reg_kind_e         dec_kind;
    logic [EVT_N-1:0]  evt_v, wbits;
    logic [EVT_N-1:0]  raw_v [NUM_LINES];
    logic [EVT_N-1:0]  en_v  [NUM_LINES];
    logic [EVT_N-1:0]  rd_bits;

    irqb_decode #(
        .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .BASE(BASE), .STRIDE(STRIDE)
    ) u_dec (
        .addr(reg_addr), .hit(dec_hit), .line(dec_line), .kind(dec_kind)
    );

    // Gather the event pulses and the write bits into internal vectors.
    always_comb begin
        evt_v           = '0;
        evt_v[EVT_ERR]  = evt_err;
        evt_v[EVT_DONE] = evt_done;
        wbits           = from_bus(reg_wdata);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic sel;
        assign sel = reg_wr && dec_hit && (dec_line == LINE_W'(i));
        irqb_line u_line (
            .clk(clk), .rst_n(rst_n), .evt(evt_v),
            .wr_raw(sel && dec_kind == KIND_RAW),
            .wr_stat(sel && dec_kind == KIND_STAT),
            .wr_set(sel && dec_kind == KIND_ENSET),
            .wr_clr(sel && dec_kind == KIND_ENCLR),
            .wbits(wbits), .raw_o(raw_v[i]), .en_o(en_v[i]), .irq_o(irq_o[i])
        );
    end

    // Read mux: select the addressed line's view; unmapped reads give zero.
    always_comb begin
        rd_bits = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (dec_hit && dec_line == LINE_W'(i)) begin
                case (dec_kind)
                    KIND_RAW:  rd_bits = raw_v[i];
                    KIND_STAT: rd_bits = raw_v[i] & en_v[i];
                    default:   rd_bits = en_v[i];
                endcase
            end
        end
        reg_rdata = to_bus(rd_bits);
    end

    wire unused_wdata = ^reg_wdata;
endmodule

// File: tb/irq_line_bank_tb.sv
// Bench: behavioural reference model, compared on every falling edge.
module irq_line_bank_tb_top;
    localparam int NL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_done = 1'b0, evt_err = 1'b0;
    logic [NL-1:0] irq_o;

    int checks = 0, errors = 0, cycles = 0;
    bit armed = 0;
    string tag = "R11";

    int raw_m [NL];
    int en_m  [NL];
    bit irq_m [NL];

    always #4 clk = ~clk;   // 125 MHz

    irq_line_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_done(evt_done), .evt_err(evt_err), .irq_o(irq_o)
    );

    function automatic bit mapped(int a, output int n, output int k);
        n = 0; k = 0;
        if (a < 'h24 || a >= 'h54 || (a % 4) != 0) return 0;
        n = (a - 'h24) / 16;
        k = ((a - 'h24) % 16) / 4;
        return 1;
    endfunction

    function automatic int model_read(int a);
        int n, k;
        if (!mapped(a, n, k)) return 0;
        case (k)
            0: return raw_m[n];
            1: return raw_m[n] & en_m[n];
            default: return en_m[n];
        endcase
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        int n, k, m, ev;
        armed = 1;
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin raw_m[i] = 0; en_m[i] = 0; irq_m[i] = 0; end
        end else begin
            for (int i = 0; i < NL; i++) irq_m[i] = ((raw_m[i] & en_m[i]) != 0);
            m  = reg_wdata & 'h101;
            ev = (evt_done ? 'h100 : 0) | (evt_err ? 1 : 0);
            if (reg_wr && mapped(int'(reg_addr), n, k)) begin
                case (k)
                    0: raw_m[n] = raw_m[n] | m;
                    1: raw_m[n] = raw_m[n] & ~m;
                    2: en_m[n]  = en_m[n] | m;
                    default: en_m[n] = en_m[n] & ~m;
                endcase
            end
            for (int i = 0; i < NL; i++) raw_m[i] = raw_m[i] | ev;
        end
    end

    // Compare outputs against the model at each falling edge.
    always @(negedge clk) begin
        if (armed) begin
            int exp_rd;
            exp_rd = model_read(int'(reg_addr));
            checks++;
            if (reg_rdata !== 32'(exp_rd)) begin
                errors++;
                $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, reg_addr, reg_rdata, exp_rd);
            end
            for (int i = 0; i < NL; i++) begin
                checks++;
                if (irq_o[i] !== irq_m[i]) begin
                    errors++;
                    $display("FAIL R8 (%s) irq line %0d actual=%b expected=%b", tag, i, irq_o[i], irq_m[i]);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic step(bit wr, int a, int d, bit dn, bit er);
        @(posedge clk);
        #2;
        reg_wr = wr; reg_addr = 12'(a); reg_wdata = 32'(d);
        evt_done = dn; evt_err = er;
    endtask

    task automatic rd(int a);
        step(0, a, 0, 0, 0);
    endtask

    task automatic sweep();
        for (int a = 'h20; a < 'h58; a += 4) rd(a);
    endtask

    initial begin
        repeat (3) step(0, 0, 0, 0, 0);
        tag = "R11"; sweep();
        rst_n = 1'b1;
        tag = "R1"; sweep(); rd('h25); rd('h2E); rd('h60);
        step(1, 'h26, 'h101, 0, 0); step(1, 'h54, 'h101, 0, 0); sweep();
        tag = "R3"; step(0, 'h24, 0, 1, 0); rd('h34); step(0, 'h44, 0, 0, 1); rd('h28); sweep();
        tag = "R6"; step(1, 'h28, 'h100, 0, 0); rd('h24); step(1, 'h38, 'h001, 0, 0); sweep();
        tag = "R2"; step(1, 'h34, 'hFFFF_FFFF, 0, 0); rd('h34); step(1, 'h3C, 'hFFFF_FEFE, 0, 0); sweep();
        tag = "R4"; step(1, 'h24, 'h100, 0, 0); rd('h24); step(1, 'h44, 'h001, 0, 0); rd('h44);
        tag = "R7"; step(1, 'h2C, 'h100, 0, 0); rd('h30); rd('h2C); step(1, 'h3C, 'h101, 0, 0); rd('h40);
        tag = "R5"; rd('h28); rd('h38); rd('h48); step(1, 'h4C, 'h001, 0, 0); rd('h48);
        tag = "R8"; rd('h28); rd('h28); step(1, 'h28, 'h100, 0, 0); rd('h28); rd('h28);
        tag = "R10"; step(1, 'h24, 0, 0, 0); step(1, 'h28, 0, 0, 0); step(1, 'h30, 0, 0, 0);
        step(1, 'h40, 0, 0, 0); sweep();
        tag = "R9"; step(1, 'h2C, 'h101, 0, 0); step(1, 'h28, 'h101, 1, 1); rd('h24); rd('h28);
        step(1, 'h38, 'h101, 0, 1); rd('h34);
        tag = "R7"; step(1, 'h30, 'h101, 0, 0); rd('h2C); rd('h28);
        tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            int a, d, r;
            r = $urandom_range(0, 7);
            a = 'h24 + 4 * $urandom_range(0, 11);
            if (r == 7) a = $urandom_range(0, 'h7F);
            case ($urandom_range(0, 4))
                0: d = 'h101; 1: d = 'h100; 2: d = 'h001; 3: d = 0;
                default: d = $urandom;
            endcase
            step($urandom_range(0, 1), a, d, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
        end
        tag = "R11"; step(0, 'h2C, 0, 0, 0); rst_n = 1'b0; rd('h2C); rd('h24); rst_n = 1'b1; sweep();
        rd(0);
        @(posedge clk); #2;
        finish_run();
    end
endmodule